// File: doc/BRIEF.md
# Vector Carry-Less Multiply-Sum Unit

This unit takes two 128-bit vector operands and a select code. It cuts both operands into lanes of equal width: 8, 16, 32 or 64 bits, chosen per operation at run time. For each pair of lanes it forms a carry-less product, which is a GF(2) polynomial multiplication where partial products combine by XOR. Each product is twice the lane width. Every two neighbouring lane products are then XOR-summed into one double-width element of the 128-bit result.

The datapath is iterative. Each cycle it handles one multiplier bit position in all lanes at once, so an operation takes as many cycles as the lane is wide. Operands are accepted through a valid/ready handshake, and completion is signalled by a one-cycle valid pulse. A select code that names no mode is rejected at once with an error flag. The unit is meant to sit behind an issue stage that already holds both operands, for example as part of a CRC or GCM hashing path.

Top module: `clmul_sum_unit`

## Requirements
- R1: `in_sel` picks the lane width W. Code 16 gives 8 bits, 17 gives 16 bits, 18 gives 32 bits and 19 gives 64 bits. Every mode consumes two 128-bit operands and produces one 128-bit result made of elements of width 2W.
- R2: Source elements are numbered from the most significant end, and result element i pairs source elements 2i and 2i+1. Result element i equals P(2i) XOR P(2i+1), and it occupies the bit positions that those two source elements cover. P(n) is the 2W-bit carry-less product of element n of A and element n of B: the sum over every set bit j of the A element of the B element shifted left by j, with bits shifted past W landing in the upper half.
- R3: In 64-bit mode the result is the XOR of the two 128-bit lane products. For example, when A holds 1 in both 64-bit halves, the result is the XOR of B's two halves, zero-extended.
- R4: The most significant bit of every result element is 0 in every legal mode.
- R5: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge that accepts a legal code until the operation completes.
- R6: For a legal code, `out_valid` is 1 during exactly one cycle: the cycle that follows the W-th rising edge after the accepting edge. `in_ready` is 1 again in that same cycle.
- R7: A code other than 16 to 19 is still accepted. In the cycle after the accepting edge, `out_valid` and `out_err` are both 1 and `out_result` is all zeros. `in_ready` stays 1.
- R8: `out_err` is 0 when a legal operation completes.
- R9: While `in_ready` is 0, `in_valid` and new operand values have no effect on the result of the running operation. `out_result` holds its value until the next acceptance.
- R10: After reset, `in_ready` is 1, while `out_valid`, `out_err` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select code are presented |
| in_ready | output | 1 | Unit is idle and can take an operation |
| in_sel | input | 5 | Mode select code (16 to 19 legal) |
| in_a | input | 128 | Multiplier vector A |
| in_b | input | 128 | Multiplicand vector B |
| out_valid | output | 1 | Result or error is presented for one cycle |
| out_err | output | 1 | The accepted code was illegal |
| out_result | output | 128 | Multiply-sum result |

## Verification
The latency and single-completion properties assume that nothing upstream forces the unit: every operation starts only through the handshake, and reset is applied before the first operation. The stimulus drives inputs on falling edges and offers a new operation only while `in_ready` is high. During the busy-window test it keeps `in_valid` asserted with different operands, so the rule that inputs are ignored while busy is exercised, not just assumed. Back-to-back illegal codes are allowed to produce consecutive error pulses, so the single-pulse property is stated only for legal completions.

// File: rtl/clms_pkg.sv
package clms_pkg;
  localparam int VEC_W     = 128;
  localparam int BASE_W    = 8;
  localparam int NUM_MODES = 4;
  localparam int CODE_W    = 5;
  localparam int CODE_BASE = 16;
  localparam int MAX_W     = BASE_W << (NUM_MODES - 1);
  localparam int IDX_W     = $clog2(MAX_W);
  localparam int MODE_W    = $clog2(NUM_MODES);

  // Number of multiplier bits stepped for a mode index.
  function automatic int unsigned lane_bits(input int unsigned mode);
    return BASE_W << mode;
  endfunction
endpackage

// File: rtl/clms_seq.sv
module clms_seq
  import clms_pkg::*;
#(
  parameter int P_NUM_MODES = NUM_MODES,
  parameter int P_BASE_W    = BASE_W,
  parameter int P_CODE_W    = CODE_W,
  parameter int P_CODE_BASE = CODE_BASE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [P_CODE_W-1:0]       in_sel,
  output logic                      in_ready,
  output logic                      accept,
  output logic                      accept_bad,
  output logic                      busy,
  output logic [$clog2(P_BASE_W << (P_NUM_MODES-1))-1:0] bit_idx,
  output logic [$clog2(P_NUM_MODES)-1:0] mode_q,
  output logic                      out_valid,
  output logic                      out_err
);
  localparam int L_MAX_W  = P_BASE_W << (P_NUM_MODES - 1);
  localparam int L_IDX_W  = $clog2(L_MAX_W);
  localparam int L_LW_W   = L_IDX_W + 1;
  localparam int L_MODE_W = $clog2(P_NUM_MODES);
  localparam logic [P_CODE_W-1:0] CODE_LO = P_CODE_W'(P_CODE_BASE);
  localparam logic [P_CODE_W-1:0] CODE_HI = P_CODE_W'(P_CODE_BASE + P_NUM_MODES - 1);

  logic                busy_q;
  logic [L_IDX_W-1:0]  cnt_q;
  logic                sel_ok;
  logic [L_MODE_W-1:0] sel_mode;
  logic [L_LW_W-1:0]   lane_w;
  logic                last_step;

  assign sel_ok     = (in_sel >= CODE_LO) && (in_sel <= CODE_HI);
  assign sel_mode   = L_MODE_W'(in_sel - CODE_LO);
  assign in_ready   = !busy_q;
  assign accept     = in_valid && in_ready;
  assign accept_bad = accept && !sel_ok;
  assign busy       = busy_q;
  assign bit_idx    = cnt_q;
  assign lane_w     = L_LW_W'(P_BASE_W) << mode_q;
  assign last_step  = busy_q && ({1'b0, cnt_q} == lane_w - L_LW_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      mode_q    <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else if (accept) begin
      busy_q    <= sel_ok;
      cnt_q     <= '0;
      mode_q    <= sel_ok ? sel_mode : '0;
      out_valid <= !sel_ok;
      out_err   <= !sel_ok;
    end else if (busy_q) begin
      cnt_q     <= cnt_q + L_IDX_W'(1);
      busy_q    <= !last_step;
      out_valid <= last_step;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/clms_step.sv
module clms_step
  import clms_pkg::*;
#(
  parameter int P_VEC_W     = VEC_W,
  parameter int P_BASE_W    = BASE_W,
  parameter int P_NUM_MODES = NUM_MODES
) (
  input  logic [P_VEC_W-1:0] a,
  input  logic [P_VEC_W-1:0] b,
  input  logic [$clog2(P_BASE_W << (P_NUM_MODES-1))-1:0] k,
  input  logic [$clog2(P_NUM_MODES)-1:0] mode,
  output logic [P_VEC_W-1:0] contrib
);
  logic [P_NUM_MODES-1:0][P_VEC_W-1:0] per_mode;

  // One partial-product layer per mode; the active one is selected below.
  for (genvar m = 0; m < P_NUM_MODES; m++) begin : g_mode
    localparam int W  = P_BASE_W << m;
    localparam int NE = P_VEC_W / (2 * W);
    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [W-1:0]   a_up, a_dn, b_up, b_dn, a_up_sh, a_dn_sh;
      logic [2*W-1:0] pp_up, pp_dn;
      assign a_up    = a[e*2*W + W +: W];
      assign a_dn    = a[e*2*W +: W];
      assign b_up    = b[e*2*W + W +: W];
      assign b_dn    = b[e*2*W +: W];
      assign a_up_sh = a_up >> k;
      assign a_dn_sh = a_dn >> k;
      assign pp_up   = a_up_sh[0] ? ({{W{1'b0}}, b_up} << k) : '0;
      assign pp_dn   = a_dn_sh[0] ? ({{W{1'b0}}, b_dn} << k) : '0;
      assign per_mode[m][e*2*W +: 2*W] = pp_up ^ pp_dn;
    end
  end

  assign contrib = per_mode[mode];
endmodule

// File: rtl/clmul_sum_unit.sv
module clmul_sum_unit
  import clms_pkg::*;
#(
  parameter int P_VEC_W     = VEC_W,
  parameter int P_BASE_W    = BASE_W,
  parameter int P_NUM_MODES = NUM_MODES,
  parameter int P_CODE_W    = CODE_W,
  parameter int P_CODE_BASE = CODE_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [P_CODE_W-1:0]  in_sel,
  input  logic [P_VEC_W-1:0]   in_a,
  input  logic [P_VEC_W-1:0]   in_b,
  output logic                 out_valid,
  output logic                 out_err,
  output logic [P_VEC_W-1:0]   out_result
);
  localparam int L_IDX_W  = $clog2(P_BASE_W << (P_NUM_MODES - 1));
  localparam int L_MODE_W = $clog2(P_NUM_MODES);

  logic                accept, accept_bad, busy;
  logic [L_IDX_W-1:0]  bit_idx;
  logic [L_MODE_W-1:0] mode_q;
  logic [P_VEC_W-1:0]  a_q, b_q, acc_q, contrib;

  clms_seq #(
    .P_NUM_MODES(P_NUM_MODES), .P_BASE_W(P_BASE_W),
    .P_CODE_W(P_CODE_W), .P_CODE_BASE(P_CODE_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_ready(in_ready), .accept(accept), .accept_bad(accept_bad),
    .busy(busy), .bit_idx(bit_idx), .mode_q(mode_q),
    .out_valid(out_valid), .out_err(out_err)
  );

  clms_step #(
    .P_VEC_W(P_VEC_W), .P_BASE_W(P_BASE_W), .P_NUM_MODES(P_NUM_MODES)
  ) u_step (
    .a(a_q), .b(b_q), .k(bit_idx), .mode(mode_q), .contrib(contrib)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (accept) begin
      a_q   <= in_a;
      b_q   <= in_b;
      acc_q <= '0;
    end else if (busy) begin
      acc_q <= acc_q ^ contrib;
    end
  end

  assign out_result = acc_q;
endmodule

// File: rtl/clms_chk.sv
module clms_chk
  import clms_pkg::*;
#(
  parameter int P_VEC_W     = VEC_W,
  parameter int P_BASE_W    = BASE_W,
  parameter int P_NUM_MODES = NUM_MODES
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_ready,
  input logic                         accept,
  input logic                         accept_bad,
  input logic                         busy,
  input logic [$clog2(P_NUM_MODES)-1:0] mode_q,
  input logic                         out_valid,
  input logic                         out_err,
  input logic [P_VEC_W-1:0]           out_result
);
  logic [7:0] lat_q;
  logic       good_done;

  assign good_done = out_valid && !out_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_q <= '0;
    else if (accept)           lat_q <= '0;
    else if (lat_q != 8'hFF)   lat_q <= lat_q + 8'd1;
  end

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accept_bad) |=> !in_ready);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good_done |-> (lat_q == 8'(P_BASE_W << mode_q)));

  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good_done |=> !good_done);

  assert_bad_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (out_valid && out_err && in_ready));

  assert_bad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_result == '0));

  assert_msb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_result[P_VEC_W-1]);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !busy) |=> $stable(out_result));
endmodule

bind clmul_sum_unit clms_chk #(
  .P_VEC_W(P_VEC_W), .P_BASE_W(P_BASE_W), .P_NUM_MODES(P_NUM_MODES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .accept(accept),
  .accept_bad(accept_bad), .busy(busy), .mode_q(mode_q),
  .out_valid(out_valid), .out_err(out_err), .out_result(out_result)
);

// File: tb/tb_clmul_sum_unit.sv
module tb_clmul_sum_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   in_sel = '0;
  logic [127:0] in_a = '0, in_b = '0;
  logic         in_ready, out_valid, out_err;
  logic [127:0] out_result;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  clmul_sum_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_err(out_err), .out_result(out_result)
  );

  // Bit-level restatement: result bit (base+i+j) toggles for each a_i & b_j pair.
  function automatic logic [127:0] ref_sum(input logic [127:0] a, b, input int w);
    logic [127:0] r = '0;
    for (int e = 0; e < 128 / (2 * w); e++)
      for (int h = 0; h < 2; h++)
        for (int i = 0; i < w; i++)
          for (int j = 0; j < w; j++)
            if (a[e*2*w + h*w + i] && b[e*2*w + h*w + j]) r[e*2*w + i + j] ^= 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optional busy-window noise on the inputs.
  task automatic run_op(input string req, input logic [127:0] a, b,
                        input logic [4:0] code, input logic noise);
    int w, cyc;
    logic legal;
    logic [127:0] exp;
    legal = (code >= 5'd16 && code <= 5'd19);
    w     = legal ? (8 << (code - 5'd16)) : 0;
    exp   = legal ? ref_sum(a, b, w) : '0;
    @(negedge clk);
    check({req, " ready before op (R5)"}, {127'b0, in_ready}, 128'd1);
    in_valid = 1'b1; in_a = a; in_b = b; in_sel = code;
    @(negedge clk);
    if (noise) begin
      in_a = ~a; in_b = b ^ {128{1'b1}}; in_sel = 5'd16;
      check({req, " busy ready low R5"}, {127'b0, in_ready}, 128'd0);
    end else in_valid = 1'b0;
    cyc = 0;
    while (!out_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    check({req, " latency R6"}, 128'(cyc), 128'(w));
    check({req, " err flag R7/R8"}, {127'b0, out_err}, {127'b0, !legal});
    check({req, " result R2"}, out_result, exp);
    if (legal)
      check({req, " ready on done R6"}, {127'b0, in_ready}, 128'd1);
    @(negedge clk);
    check({req, " valid pulse one cycle R6"}, {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_reset;
    check("reset ready R10", {127'b0, in_ready}, 128'd1);
    check("reset valid R10", {127'b0, out_valid}, 128'd0);
    check("reset err R10", {127'b0, out_err}, 128'd0);
    check("reset result R10", out_result, '0);
  endtask

  task automatic t_zero;
    for (int m = 0; m < 4; m++) begin
      run_op("zero operands R1", '0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 5'(16 + m), 1'b0);
      run_op("zero multiplicand R1", {128{1'b1}}, '0, 5'(16 + m), 1'b0);
    end
  endtask

  task automatic t_ones;
    logic [127:0] msb;
    for (int m = 0; m < 4; m++) begin
      run_op("all ones R1", {128{1'b1}}, {128{1'b1}}, 5'(16 + m), 1'b0);
      msb = '0;
      for (int e = 0; e < 128 / (16 << m); e++) msb[e*(16 << m) + (16 << m) - 1] = 1'b1;
      check("element msb zero R4", out_result & msb, '0);
    end
  endtask

  task automatic t_single;
    logic [127:0] a;
    for (int m = 0; m < 4; m++) begin
      int w = 8 << m;
      a = '0;
      for (int e = 0; e < 128 / w; e++) a[e*w + ((e % 2 == 0) ? 0 : w - 1)] = 1'b1;
      run_op("single bit j=0 and j=W-1 R2", a, 128'hF00D_1234_8001_ABCD_55AA_0FF0_C3C3_9E37, 5'(16 + m), 1'b0);
    end
  endtask

  task automatic t_mixed;
    run_op("mixed byte R2", 128'h8137_00FF_A5C3_1E2D_7F80_0102_4466_99BB,
           128'hC0DE_F00D_1357_9BDF_2468_ACE0_FFFF_0001, 5'd16, 1'b0);
    run_op("mixed half R2", 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0,
           128'h8000_0001_7FFF_FFFE_AAAA_5555_0F0F_F0F0, 5'd17, 1'b0);
    run_op("mixed word R2", 128'h8000_0000_0000_0001_FFFF_0000_1357_2468,
           128'hFFFF_FFFF_8765_4321_0000_0003_CAFE_BABE, 5'd18, 1'b0);
  endtask

  task automatic t_dword;
    logic [63:0] p = 64'hFEDC_BA98_7654_3210, q = 64'h8000_0000_0000_0001;
    run_op("dword fold R3", {64'd1, 64'd1}, {p, q}, 5'd19, 1'b0);
    check("dword fold explicit R3", out_result, {64'd0, p ^ q});
    run_op("dword wide R3", 128'h8000_0000_0000_0000_8000_0000_0000_0001,
           128'hFFFF_FFFF_FFFF_FFFF_1111_2222_3333_4444, 5'd19, 1'b0);
  endtask

  task automatic t_illegal;
    logic [4:0] codes [4] = '{5'd0, 5'd15, 5'd20, 5'd31};
    for (int i = 0; i < 4; i++) begin
      run_op("illegal code R7", {128{1'b1}}, {128{1'b1}}, codes[i], 1'b0);
      check("illegal ready stays high R7", {127'b0, in_ready}, 128'd1);
    end
  endtask

  task automatic t_busy;
    logic [127:0] held;
    run_op("busy inputs ignored R9", 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
           128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00, 5'd17, 1'b1);
    run_op("busy inputs ignored dword R9", 128'h0000_0000_0000_00FF_0000_0000_0000_0003,
           128'hABCD_0000_0000_1234_0000_0000_5555_0000, 5'd19, 1'b1);
    held = out_result;
    repeat (3) @(negedge clk);
    check("result held while idle R9", out_result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_ones();
    t_single();
    t_mixed();
    t_dword();
    t_illegal();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule